// File: doc/BRIEF.md
# Firmware Memory Bus Target

This block sits on the four-bit multiplexed address/data bus of a low pin count host link and answers the host's firmware-memory read and write cycles. It watches the frame strobe and the shared nibble lines on every clock. It picks up the cycle start code, a four-bit device select, a 28-bit byte address and a transfer-size code. It claims the cycle only when the device select equals a strap input tied off on the board.

On a claimed write, the block gathers the data nibbles into bytes and hands each byte to a plain synchronous byte-memory port. It then answers with a ready code and hands the bus back. On a claimed read, it waits out the host's bus hand-over and fetches bytes from the same port, which has a one-clock read latency. It inserts a short-wait code while the first byte is in flight, then sends ready and streams the bytes. Transfers of 1, 2, 4, 16 or 128 bytes use consecutive addresses.

The host can cancel a cycle at any point by holding the frame strobe low for two clocks running. The block then lets go of the bus on the next clock and goes back to looking for a fresh start code.

Top module: `fwmem_target`

## Requirements
- R1: The start code is the nibble on `lad_in` in the last clock in which `frame_n` is low. 1101 opens a read and 1110 opens a write. Any other start code leaves the block idle: `lad_oe` stays 0 and `mem_we` stays 0.
- R2: The clock after the start code carries the device select. If it differs from `strap_id`, the block neither drives the bus nor writes memory until `frame_n` falls again.
- R3: The next seven clocks carry the 28-bit address, most significant nibble first. Byte i of the transfer uses `mem_addr` = start address + i, modulo 2^28.
- R4: The clock after the address carries the size code: 0000 means 1 byte, 0001 means 2, 0010 means 4, 0100 means 16 and 0111 means 128. Any other code makes the block ignore the cycle: no drive and no write.
- R5: In a write, the data nibbles follow the size code directly, low nibble of each byte first. On the clock that carries a byte's high nibble, `mem_we` is 1 and `mem_wdata` is the assembled byte. `mem_we` is 0 on every other clock.
- R6: After the last write nibble, the block leaves `lad_oe` at 0 for two clocks. It then drives 0000 for one clock and 1111 for one clock, and releases the bus on the next clock.
- R7: In a read, the block keeps `lad_oe` at 0 for the two clocks after the size code. It then drives 0101 for one clock and 0000 for one clock. After that it sends every byte, low nibble first, in ascending address order with no gaps. The memory returns `mem_rdata` one clock after it sees `mem_addr`.
- R8: After the last read nibble, the block drives 1111 for one clock and releases the bus on the next clock.
- R9: When `frame_n` is low on two consecutive clocks, `lad_oe` is 0 from the next clock on. The block then accepts the next start code normally.
- R10: After reset, and on every clock it is not driving, the block holds `lad_oe` at 0 and `lad_out` at 1111. `mem_we` and `lad_oe` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| strap_id | input | 4 | Static device-select value this target answers to |
| frame_n | input | 1 | Active-low frame strobe from the host |
| lad_in | input | 4 | Nibble currently seen on the shared bus lines |
| lad_out | output | 4 | Nibble the target drives when enabled |
| lad_oe | output | 1 | Output enable for the shared bus lines |
| mem_addr | output | 28 | Byte address to the memory port |
| mem_we | output | 1 | Write strobe to the memory port |
| mem_wdata | output | 8 | Write byte to the memory port |
| mem_rdata | input | 8 | Read byte, valid one clock after its address |

## Verification
On every cycle, the embedded properties check the following. A non-matching select sends the sequencer straight back to idle, and a bad size code does the same. Each memory write is followed by an address step. The first clock of driving is always a short-wait or ready code. The turn-around drive is followed by a release. A double-low frame strobe clears the output enable. Output enable and write strobe never meet. Only the bench's transactions can show the things that depend on real bus traffic. These are nibble ordering, address assembly, the exact clock position of every code in the read and write handshakes, the data bytes themselves across all five sizes, last-start-wins selection, and recovery after a cancelled read.

// File: rtl/fwm_pkg.sv
package fwm_pkg;

    localparam int NIB_W      = 4;
    localparam int ADDR_NIBS  = 7;
    localparam int ADDR_W     = NIB_W * ADDR_NIBS;
    localparam int BYTE_W     = 8;
    localparam int MAX_BYTES  = 128;
    localparam int LEN_W      = $clog2(MAX_BYTES);
    localparam int ACNT_W     = $clog2(ADDR_NIBS);

    localparam logic [NIB_W-1:0] CODE_RD    = 4'b1101;
    localparam logic [NIB_W-1:0] CODE_WR    = 4'b1110;
    localparam logic [NIB_W-1:0] SYNC_READY = 4'b0000;
    localparam logic [NIB_W-1:0] SYNC_SHORT = 4'b0101;
    localparam logic [NIB_W-1:0] BUS_HIGH   = 4'b1111;

    typedef enum logic [3:0] {
        S_IDLE,
        S_START,
        S_ADDR,
        S_MSIZE,
        S_WDATA,
        S_WTAR1,
        S_WTAR2,
        S_WSYNC,
        S_HTAR1,
        S_HTAR2,
        S_SWAIT,
        S_SRDY,
        S_RDATA,
        S_TDRV
    } fwm_state_e;

    typedef struct packed {
        logic             ok;
        logic [LEN_W-1:0] last;
    } size_info_t;

    typedef struct packed {
        fwm_state_e  st;
        logic        hi;
    } drv_ctl_t;

    function automatic size_info_t size_decode(input logic [NIB_W-1:0] code);
        size_info_t r;
        r.ok   = 1'b1;
        r.last = '0;
        case (code)
            4'b0000: r.last = LEN_W'(0);
            4'b0001: r.last = LEN_W'(1);
            4'b0010: r.last = LEN_W'(3);
            4'b0100: r.last = LEN_W'(15);
            4'b0111: r.last = LEN_W'(MAX_BYTES - 1);
            default: r.ok   = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/fwm_frame_watch.sv
module fwm_frame_watch (
    input  logic clk,
    input  logic rst,
    input  logic frame_n,
    output logic abort
);
    logic prev_n;

    always_ff @(posedge clk) begin
        if (rst) prev_n <= 1'b1;
        else     prev_n <= frame_n;
    end

    assign abort = !frame_n && !prev_n;

endmodule

// File: rtl/fwm_seq.sv
module fwm_seq
    import fwm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NIB_W-1:0]    strap_id,
    input  logic                frame_n,
    input  logic [NIB_W-1:0]    lad_in,
    input  logic                abort,
    output drv_ctl_t            ctl,
    output logic [BYTE_W-1:0]   data_q,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic                mem_we,
    output logic [BYTE_W-1:0]   mem_wdata,
    input  logic [BYTE_W-1:0]   mem_rdata
);
    fwm_state_e          st, nxt;
    logic [NIB_W-1:0]    start_q;
    logic [ACNT_W-1:0]   acnt;
    logic [LEN_W-1:0]    len;
    logic                hi;
    logic [NIB_W-1:0]    low_q;
    logic [ADDR_W-1:0]   addr_q;
    size_info_t          szi;
    logic                code_ok;

    assign szi     = size_decode(lad_in);
    assign code_ok = (start_q == CODE_RD) || (start_q == CODE_WR);

    always_comb begin
        nxt = st;
        if (!frame_n && (st == S_IDLE || st == S_START || abort)) begin
            nxt = S_START;
        end else begin
            case (st)
                S_START: nxt = (code_ok && lad_in == strap_id) ? S_ADDR : S_IDLE;
                S_ADDR:  if (acnt == ACNT_W'(ADDR_NIBS - 1)) nxt = S_MSIZE;
                S_MSIZE: begin
                    if (!szi.ok)                nxt = S_IDLE;
                    else if (start_q == CODE_WR) nxt = S_WDATA;
                    else                        nxt = S_HTAR1;
                end
                S_WDATA: if (hi && len == '0) nxt = S_WTAR1;
                S_WTAR1: nxt = S_WTAR2;
                S_WTAR2: nxt = S_WSYNC;
                S_WSYNC: nxt = S_TDRV;
                S_HTAR1: nxt = S_HTAR2;
                S_HTAR2: nxt = S_SWAIT;
                S_SWAIT: nxt = S_SRDY;
                S_SRDY:  nxt = S_RDATA;
                S_RDATA: if (hi && len == '0) nxt = S_TDRV;
                S_TDRV:  nxt = S_IDLE;
                default: nxt = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= S_IDLE;
            start_q <= '0;
            acnt    <= '0;
            len     <= '0;
            hi      <= 1'b0;
            low_q   <= '0;
            data_q  <= '0;
            addr_q  <= '0;
        end else begin
            st <= nxt;
            if (nxt == S_START) start_q <= lad_in;
            case (st)
                S_START: acnt <= '0;
                S_ADDR: begin
                    addr_q <= {addr_q[ADDR_W-NIB_W-1:0], lad_in};
                    acnt   <= acnt + 1'b1;
                end
                S_MSIZE: begin
                    len <= szi.last;
                    hi  <= 1'b0;
                end
                S_WDATA: begin
                    if (!hi) begin
                        low_q <= lad_in;
                        hi    <= 1'b1;
                    end else begin
                        hi     <= 1'b0;
                        addr_q <= addr_q + 1'b1;
                        if (len != '0) len <= len - 1'b1;
                    end
                end
                S_SRDY: begin
                    data_q <= mem_rdata;
                    addr_q <= addr_q + 1'b1;
                    hi     <= 1'b0;
                end
                S_RDATA: begin
                    if (!hi) begin
                        hi <= 1'b1;
                    end else begin
                        hi <= 1'b0;
                        if (len != '0) begin
                            len    <= len - 1'b1;
                            data_q <= mem_rdata;
                            addr_q <= addr_q + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign mem_addr  = addr_q;
    assign mem_we    = (st == S_WDATA) && hi;
    assign mem_wdata = {lad_in, low_q};
    assign ctl.st    = st;
    assign ctl.hi    = hi;

    // R2: a select that does not match sends the sequencer back to idle
    a_r2_mismatch_idle: assert property (@(posedge clk) disable iff (rst)
        (st == S_START && frame_n && lad_in != strap_id) |=> st == S_IDLE);

    // R4: an unsupported size code abandons the cycle
    a_r4_bad_size_idle: assert property (@(posedge clk) disable iff (rst)
        (st == S_MSIZE && frame_n && !szi.ok) |=> st == S_IDLE);

    // R3: each written byte advances the address by one
    a_r3_addr_step: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> mem_addr == $past(mem_addr) + 1'b1);

endmodule

// File: rtl/fwm_lad_drv.sv
module fwm_lad_drv
    import fwm_pkg::*;
(
    input  drv_ctl_t           ctl,
    input  logic [BYTE_W-1:0]  data_q,
    output logic [NIB_W-1:0]   lad_out,
    output logic               lad_oe
);
    always_comb begin
        lad_out = BUS_HIGH;
        lad_oe  = 1'b0;
        case (ctl.st)
            S_SWAIT: begin
                lad_oe  = 1'b1;
                lad_out = SYNC_SHORT;
            end
            S_SRDY, S_WSYNC: begin
                lad_oe  = 1'b1;
                lad_out = SYNC_READY;
            end
            S_RDATA: begin
                lad_oe  = 1'b1;
                lad_out = ctl.hi ? data_q[BYTE_W-1:NIB_W] : data_q[NIB_W-1:0];
            end
            S_TDRV: begin
                lad_oe  = 1'b1;
                lad_out = BUS_HIGH;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/fwmem_target.sv
module fwmem_target
    import fwm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NIB_W-1:0]    strap_id,
    input  logic                frame_n,
    input  logic [NIB_W-1:0]    lad_in,
    output logic [NIB_W-1:0]    lad_out,
    output logic                lad_oe,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic                mem_we,
    output logic [BYTE_W-1:0]   mem_wdata,
    input  logic [BYTE_W-1:0]   mem_rdata
);
    logic              abort;
    drv_ctl_t          ctl;
    logic [BYTE_W-1:0] data_q;

    fwm_frame_watch u_watch (
        .clk     (clk),
        .rst     (rst),
        .frame_n (frame_n),
        .abort   (abort)
    );

    fwm_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .strap_id  (strap_id),
        .frame_n   (frame_n),
        .lad_in    (lad_in),
        .abort     (abort),
        .ctl       (ctl),
        .data_q    (data_q),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata)
    );

    fwm_lad_drv u_drv (
        .ctl     (ctl),
        .data_q  (data_q),
        .lad_out (lad_out),
        .lad_oe  (lad_oe)
    );

    // R9: two low frame clocks in a row free the bus on the following clock
    a_r9_abort_release: assert property (@(posedge clk) disable iff (rst)
        (!frame_n ##1 !frame_n) |=> !lad_oe);

    // R7: driving always begins with a short-wait or ready code
    a_r7_first_drive: assert property (@(posedge clk) disable iff (rst)
        $rose(lad_oe) |-> (lad_out == SYNC_SHORT || lad_out == SYNC_READY));

    // R8: the turn-around drive clock is followed by a release
    a_r8_release: assert property (@(posedge clk) disable iff (rst)
        (ctl.st == S_TDRV) |=> !lad_oe);

    // R10: the bus is never driven during a memory write
    a_r10_no_clash: assert property (@(posedge clk) disable iff (rst)
        !(lad_oe && mem_we));

endmodule

// File: tb/fwmem_target_bench.sv
module fwmem_target_bench;

    localparam logic [3:0] STRAP = 4'h3;

    typedef struct packed {
        logic [3:0]  stn;
        logic [3:0]  id;
        logic [27:0] addr;
        logic [3:0]  ms;
        logic [7:0]  seed;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{4'hE, 4'h3, 28'h0000010, 4'h0, 8'hA1},
        '{4'hD, 4'h3, 28'h0000010, 4'h0, 8'h00},
        '{4'hE, 4'h3, 28'hABCDE20, 4'h1, 8'h37},
        '{4'hD, 4'h3, 28'hABCDE20, 4'h1, 8'h00},
        '{4'hE, 4'h3, 28'h1234530, 4'h2, 8'hC4},
        '{4'hD, 4'h3, 28'h1234530, 4'h2, 8'h00},
        '{4'hE, 4'h3, 28'h0000040, 4'h4, 8'h5E},
        '{4'hD, 4'h3, 28'h0000040, 4'h4, 8'h00},
        '{4'hD, 4'h3, 28'h0FFFF80, 4'h7, 8'h00},
        '{4'hE, 4'h3, 28'h7000000, 4'h7, 8'h05},
        '{4'hD, 4'h3, 28'h7000004, 4'h2, 8'h00},
        '{4'hE, 4'h9, 28'h0000050, 4'h1, 8'h66},
        '{4'hD, 4'hC, 28'h0000050, 4'h2, 8'h00}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_n = 1'b1;
    logic [3:0]  lad_in = 4'hF;
    logic [3:0]  lad_out;
    logic        lad_oe;
    logic [27:0] mem_addr;
    logic        mem_we;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;

    logic [7:0]  bmem   [256];
    logic [7:0]  shadow [256];

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    fwmem_target u_fwmem_target (
        .clk       (clk),
        .rst       (rst),
        .strap_id  (STRAP),
        .frame_n   (frame_n),
        .lad_in    (lad_in),
        .lad_out   (lad_out),
        .lad_oe    (lad_oe),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata)
    );

    function automatic logic [7:0] pat(input int i);
        return 8'(i * 29 + 71);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) bmem[i] <= pat(i);
            mem_rdata <= 8'h00;
        end else begin
            if (mem_we) bmem[mem_addr[7:0]] <= mem_wdata;
            mem_rdata <= bmem[mem_addr[7:0]];
        end
    end

    function automatic int nbytes(input logic [3:0] ms);
        case (ms)
            4'h0: return 1;
            4'h1: return 2;
            4'h2: return 4;
            4'h4: return 16;
            4'h7: return 128;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic slot(input logic f, input logic [3:0] l);
        @(negedge clk);
        frame_n = f;
        lad_in  = l;
        #1;
    endtask

    task automatic txn(input logic [3:0] stn, input logic [3:0] id, input logic [27:0] a,
                       input logic [3:0] ms, input logic [7:0] seed,
                       input bit pre_en, input logic [3:0] pre);
        int    n;
        bit    wr;
        bit    claim;
        string why;
        n     = nbytes(ms);
        wr    = (stn == 4'hE);
        claim = (stn == 4'hD || stn == 4'hE) && id == STRAP && n != 0;
        if (!(stn == 4'hD || stn == 4'hE)) why = "R1 unknown start ignored";
        else if (id != STRAP)              why = "R2 select mismatch ignored";
        else                               why = "R4 bad size ignored";
        if (pre_en) slot(1'b0, pre);
        slot(1'b0, stn);
        chk("R10 no drive during start", {31'd0, lad_oe}, 32'd0);
        slot(1'b1, id);
        for (int k = 0; k < 7; k++) slot(1'b1, a[27-4*k -: 4]);
        slot(1'b1, ms);
        chk("R10 no drive during header", {31'd0, lad_oe}, 32'd0);
        if (!claim) begin
            int extra;
            extra = ((n == 0) ? 2 : 2 * n) + 8;
            for (int k = 0; k < extra; k++) begin
                slot(1'b1, 4'(k));
                chk(why, {30'd0, lad_oe, mem_we}, 32'd0);
            end
        end else if (wr) begin
            for (int i = 0; i < n; i++) begin
                logic [7:0]  b;
                logic [27:0] ea;
                b  = seed + 8'(i * 13);
                ea = a + 28'(i);
                slot(1'b1, b[3:0]);
                chk("R5 no strobe on low nibble", {31'd0, mem_we}, 32'd0);
                slot(1'b1, b[7:4]);
                chk("R5 strobe on high nibble", {31'd0, mem_we}, 32'd1);
                chk("R5 write byte", {24'd0, mem_wdata}, {24'd0, b});
                chk("R3 write address", {4'd0, mem_addr}, {4'd0, ea});
                shadow[ea[7:0]] = b;
            end
            slot(1'b1, 4'hF);
            chk("R6 host turn-around 1 undriven", {31'd0, lad_oe}, 32'd0);
            slot(1'b1, 4'hF);
            chk("R6 host turn-around 2 undriven", {31'd0, lad_oe}, 32'd0);
            slot(1'b1, 4'hF);
            chk("R6 ready code", {27'd0, lad_oe, lad_out}, {27'd0, 1'b1, 4'h0});
            slot(1'b1, 4'hF);
            chk("R6 drive high", {27'd0, lad_oe, lad_out}, {27'd0, 1'b1, 4'hF});
            slot(1'b1, 4'hF);
            chk("R6 release", {27'd0, lad_oe, lad_out}, {27'd0, 1'b0, 4'hF});
        end else begin
            slot(1'b1, 4'hF);
            chk("R7 host turn-around 1 undriven", {31'd0, lad_oe}, 32'd0);
            slot(1'b1, 4'hF);
            chk("R7 host turn-around 2 undriven", {31'd0, lad_oe}, 32'd0);
            slot(1'b1, 4'hF);
            chk("R7 short wait code", {27'd0, lad_oe, lad_out}, {27'd0, 1'b1, 4'h5});
            slot(1'b1, 4'hF);
            chk("R7 ready code", {27'd0, lad_oe, lad_out}, {27'd0, 1'b1, 4'h0});
            for (int i = 0; i < n; i++) begin
                logic [7:0] e;
                e = shadow[8'(a + 28'(i))];
                slot(1'b1, 4'hF);
                chk("R7 R3 read low nibble", {27'd0, lad_oe, lad_out}, {27'd0, 1'b1, e[3:0]});
                slot(1'b1, 4'hF);
                chk("R7 R3 read high nibble", {27'd0, lad_oe, lad_out}, {27'd0, 1'b1, e[7:4]});
            end
            slot(1'b1, 4'hF);
            chk("R8 drive high", {27'd0, lad_oe, lad_out}, {27'd0, 1'b1, 4'hF});
            slot(1'b1, 4'hF);
            chk("R8 release", {27'd0, lad_oe, lad_out}, {27'd0, 1'b0, 4'hF});
        end
        slot(1'b1, 4'hF);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) shadow[i] = pat(i);
        repeat (3) @(negedge clk);
        #1;
        chk("R10 reset output enable", {31'd0, lad_oe}, 32'd0);
        chk("R10 reset bus level", {28'd0, lad_out}, 32'hF);
        chk("R10 reset write strobe", {31'd0, mem_we}, 32'd0);
        rst = 1'b0;
        slot(1'b1, 4'hF);
        slot(1'b1, 4'hF);

        for (int v = 0; v < NV; v++)
            txn(VECS[v].stn, VECS[v].id, VECS[v].addr, VECS[v].ms, VECS[v].seed, 1'b0, 4'h0);

        // R4: reserved size code, then a normal read still works
        txn(4'hD, STRAP, 28'h0000060, 4'h3, 8'h00, 1'b0, 4'h0);
        txn(4'hE, STRAP, 28'h0000060, 4'h5, 8'h12, 1'b0, 4'h0);
        txn(4'hD, STRAP, 28'h0000060, 4'h1, 8'h00, 1'b0, 4'h0);

        // R1: last start code wins
        txn(4'h0, STRAP, 28'h0000010, 4'h0, 8'h00, 1'b1, 4'hD);
        txn(4'hD, STRAP, 28'h0000010, 4'h2, 8'h00, 1'b1, 4'h0);
        txn(4'hE, STRAP, 28'h00000A0, 4'h0, 8'h9B, 1'b1, 4'hD);

        // R9: cancel a read in its data phase
        slot(1'b0, 4'hD);
        slot(1'b1, STRAP);
        for (int k = 0; k < 7; k++) slot(1'b1, 4'h0);
        slot(1'b1, 4'h2);
        repeat (4) slot(1'b1, 4'hF);
        slot(1'b1, 4'hF);
        slot(1'b1, 4'hF);
        chk("R9 driving before cancel", {31'd0, lad_oe}, 32'd1);
        slot(1'b0, 4'hF);
        slot(1'b0, 4'hF);
        slot(1'b0, 4'hF);
        chk("R9 released after double low frame", {31'd0, lad_oe}, 32'd0);
        slot(1'b1, 4'hF);
        chk("R9 stays released", {31'd0, lad_oe}, 32'd0);
        slot(1'b1, 4'hF);
        txn(4'hD, STRAP, 28'h0000040, 4'h1, 8'h00, 1'b0, 4'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule